// File: doc/BRIEF.md
# Microprocessor Bus Byte-FIFO Bridge

This block connects a simple asynchronous microprocessor bus to two byte FIFOs: a receive queue filled by a link-side agent and a transmit queue drained by it. The bus has an active-low select, a single address line, active-low read and write strobes, an input data byte and an output data byte with an output enable. The address line selects one of two targets. Address 0 is the data pipe. Address 1 is the status byte on reads and a send-immediate command on writes.

All bus inputs first pass through a two-flop synchronizer. Each operation fires once, on the falling edge of the synchronized strobe, and only while the synchronized select is low. The read result is captured in a holding register that drives the output bus. The link side pushes received bytes, pops transmit bytes, and receives a one-cycle flush pulse for each send-immediate command. The link side also supplies two state flags, suspend and configured, which are synchronized before they appear in the status byte.

Top module: `cpubus_fifo_bridge`

## Requirements
- R1: After reset the output enable, the flush pulse and the overflow flag are low, and a status read reports the receive queue empty (bit 0 = 0) and the transmit queue with space (bit 1 = 1).
- R2: While select is high, a strobe pops nothing, pushes nothing and produces no flush pulse, whatever the address and data inputs are.
- R3: With select low and address 0, a read strobe returns the oldest byte of the receive queue and removes it, so bytes come back in arrival order.
- R4: With select low and address 1, a read strobe returns the status byte: bit 0 receive data present, bit 1 transmit space free, bit 2 suspend, bit 3 configured, bits 7..4 zero.
- R5: With select low and address 0, a write strobe appends the data byte to the transmit queue, and the link side sees the bytes in write order.
- R6: With select low and address 1, a write strobe raises the flush output for exactly one clock cycle and stores no byte. This also happens when the transmit queue is empty.
- R7: A strobe held low moves at most one byte, however long it is held.
- R8: A data read from an empty receive queue returns the byte returned last and leaves the queue empty.
- R9: A data write to a full transmit queue is dropped, and the overflow output rises and stays high until reset.
- R10: The output enable is high only while both select and read are low (after synchronization). A write or an idle bus leaves it low.
- R11: The suspend and configured inputs reach status bits 2 and 3 through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_addr | input | 1 | 0 = data pipe, 1 = status / send-immediate |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_din | input | 8 | Write data from the processor |
| bus_dout | output | 8 | Read data toward the processor |
| bus_oe | output | 1 | Enable for the read data driver |
| lnk_rx_push | input | 1 | Link pushes a received byte |
| lnk_rx_data | input | 8 | Received byte |
| lnk_rx_full | output | 1 | Receive queue full |
| lnk_tx_pop | input | 1 | Link takes the head transmit byte |
| lnk_tx_data | output | 8 | Head byte of the transmit queue |
| lnk_tx_avail | output | 1 | Transmit queue holds data |
| lnk_flush | output | 1 | One-cycle send-immediate pulse |
| lnk_suspend | input | 1 | Link suspended flag |
| lnk_configured | input | 1 | Link configured flag |
| tx_overflow | output | 1 | Sticky transmit drop flag |

## Verification
A pointer or count that goes wrong in either queue shows at the ports in the next data transfer. The byte comes back out of order, repeated, or missing, on the bus or at the link transmit output. The status bits change to match within one read. A faulty edge detector shows as extra pops or extra flush pulses while a strobe is held low, about three clocks after the strobe falls. A decode error shows as a status byte where a data byte should be, or as a byte stored by a send-immediate. A stuck output enable shows during any write or idle window.

// File: rtl/cbfb_pkg.sv
package cbfb_pkg;
   localparam int STAT_RX_AVAIL = 0;
   localparam int STAT_TX_SPACE = 1;
   localparam int STAT_SUSPEND  = 2;
   localparam int STAT_CONFIG   = 3;
   localparam int STAT_USED     = 4;
   localparam bit ADDR_DATA     = 1'b0;
   localparam bit ADDR_CTRL     = 1'b1;
endpackage

// File: rtl/cbfb_sync.sv
module cbfb_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cbfb_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[i] <= RST_VAL;
         else if (i == 0) stage[i] <= d;
         else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/cbfb_fifo.sv
module cbfb_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cbfb_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   // R9: a push into a full queue with no pop leaves the level unchanged
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (count == $past(count)));

   // R8: a pop from an empty queue with no push keeps it empty
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> empty);
endmodule

// File: rtl/cpubus_fifo_bridge.sv
module cpubus_fifo_bridge
   import cbfb_pkg::*;
#(
   parameter int DW       = 8,
   parameter int RX_DEPTH = 4,
   parameter int TX_DEPTH = 4,
   parameter int SYNC_STG = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel_n,
   input  logic          bus_addr,
   input  logic          bus_rd_n,
   input  logic          bus_wr_n,
   input  logic [DW-1:0] bus_din,
   output logic [DW-1:0] bus_dout,
   output logic          bus_oe,
   input  logic          lnk_rx_push,
   input  logic [DW-1:0] lnk_rx_data,
   output logic          lnk_rx_full,
   input  logic          lnk_tx_pop,
   output logic [DW-1:0] lnk_tx_data,
   output logic          lnk_tx_avail,
   output logic          lnk_flush,
   input  logic          lnk_suspend,
   input  logic          lnk_configured,
   output logic          tx_overflow
);
   localparam int CTRL_W = 4;
   localparam int BUS_W  = CTRL_W + DW;
   localparam logic [BUS_W-1:0] BUS_IDLE = {4'b1011, {DW{1'b0}}};

   if (DW < STAT_USED) begin : g_bad_dw
      $error("cpubus_fifo_bridge: DW too narrow for the status byte");
   end

   // synchronize the bus
   logic [BUS_W-1:0] bus_s;
   logic             sel_s, addr_s, rd_s, wr_s;
   logic [DW-1:0]    din_s;

   cbfb_sync #(.W(BUS_W), .STAGES(SYNC_STG), .RST_VAL(BUS_IDLE)) u_bus_sync (
      .clk(clk), .rst_n(rst_n),
      .d({bus_sel_n, bus_addr, bus_rd_n, bus_wr_n, bus_din}),
      .q(bus_s)
   );
   assign {sel_s, addr_s, rd_s, wr_s, din_s} = bus_s;

   logic [1:0] lnk_flags_s;
   cbfb_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b00)) u_flag_sync (
      .clk(clk), .rst_n(rst_n),
      .d({lnk_configured, lnk_suspend}),
      .q(lnk_flags_s)
   );

   // strobe edges
   logic rd_prev, wr_prev, rd_fall, wr_fall;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev <= 1'b1;
         wr_prev <= 1'b1;
      end else begin
         rd_prev <= rd_s;
         wr_prev <= wr_s;
      end
   end
   assign rd_fall = rd_prev && !rd_s && !sel_s;
   assign wr_fall = wr_prev && !wr_s && !sel_s;

   // queues
   logic          rx_empty, tx_empty, tx_full;
   logic [DW-1:0] rx_head;
   logic          rx_pop, tx_push;

   assign rx_pop  = rd_fall && (addr_s == ADDR_DATA);
   assign tx_push = wr_fall && (addr_s == ADDR_DATA);

   cbfb_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n),
      .push(lnk_rx_push), .wdata(lnk_rx_data),
      .pop(rx_pop), .head(rx_head),
      .empty(rx_empty), .full(lnk_rx_full)
   );

   cbfb_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(din_s),
      .pop(lnk_tx_pop), .head(lnk_tx_data),
      .empty(tx_empty), .full(tx_full)
   );
   assign lnk_tx_avail = !tx_empty;

   // status byte
   logic [DW-1:0] status;
   always_comb begin
      status = '0;
      status[STAT_RX_AVAIL] = !rx_empty;
      status[STAT_TX_SPACE] = !tx_full;
      status[STAT_SUSPEND]  = lnk_flags_s[0];
      status[STAT_CONFIG]   = lnk_flags_s[1];
   end

   // read hold, output enable, flush and overflow
   logic [DW-1:0] hold_q;
   logic          oe_q, flush_q, ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         oe_q    <= 1'b0;
         flush_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         oe_q    <= !sel_s && !rd_s;
         flush_q <= wr_fall && (addr_s == ADDR_CTRL);
         if (tx_push && tx_full) ovf_q <= 1'b1;
         if (rd_fall) begin
            if (addr_s == ADDR_CTRL) hold_q <= status;
            else if (!rx_empty)      hold_q <= rx_head;
         end
      end
   end

   assign bus_dout    = hold_q;
   assign bus_oe      = oe_q;
   assign lnk_flush   = flush_q;
   assign tx_overflow = ovf_q;

   // R6: send-immediate yields a single-cycle pulse
   a_r6_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_flush |=> !lnk_flush);

   // R2: an idle select produces no flush in the following cycle
   a_r2_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sel_s |=> !lnk_flush);

   // R9: the overflow flag never clears outside reset
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tx_overflow |=> tx_overflow);

   // R10: output enable follows a selected read
   a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_s || rd_s) |=> !bus_oe);

   // R4: upper status bits stay zero
   a_r4_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
      status[DW-1:STAT_USED] == '0);
endmodule

// File: tb/cpubus_fifo_bridge_tb.sv
module cpubus_fifo_bridge_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel_n = 1'b1, bus_addr = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [7:0] bus_din = '0;
   logic [7:0] bus_dout;
   logic       bus_oe;
   logic       lnk_rx_push = 1'b0;
   logic [7:0] lnk_rx_data = '0;
   logic       lnk_rx_full;
   logic       lnk_tx_pop = 1'b0;
   logic [7:0] lnk_tx_data;
   logic       lnk_tx_avail;
   logic       lnk_flush;
   logic       lnk_suspend = 1'b0, lnk_configured = 1'b0;
   logic       tx_overflow;

   int n_checks = 0, n_fail = 0, flush_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cpubus_fifo_bridge u_dut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel_n(bus_sel_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
      .lnk_rx_push(lnk_rx_push), .lnk_rx_data(lnk_rx_data), .lnk_rx_full(lnk_rx_full),
      .lnk_tx_pop(lnk_tx_pop), .lnk_tx_data(lnk_tx_data), .lnk_tx_avail(lnk_tx_avail),
      .lnk_flush(lnk_flush), .lnk_suspend(lnk_suspend), .lnk_configured(lnk_configured),
      .tx_overflow(tx_overflow)
   );

   always @(negedge clk) if (rst_n && lnk_flush) flush_cnt++;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic rx_load(input logic [7:0] b);
      @(negedge clk);
      lnk_rx_push = 1'b1; lnk_rx_data = b;
      @(negedge clk);
      lnk_rx_push = 1'b0;
   endtask

   task automatic tx_take(output logic [7:0] b);
      @(negedge clk);
      b = lnk_tx_data;
      lnk_tx_pop = 1'b1;
      @(negedge clk);
      lnk_tx_pop = 1'b0;
   endtask

   task automatic bus_read(input logic a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = a; bus_rd_n = 1'b0;
      repeat (4) @(negedge clk);
      d = bus_dout; oe = bus_oe;
      bus_rd_n = 1'b1; bus_sel_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic bus_write(input logic a, input logic [7:0] v, output logic oe);
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = a; bus_din = v; bus_wr_n = 1'b0;
      repeat (4) @(negedge clk);
      oe = bus_oe;
      bus_wr_n = 1'b1; bus_sel_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d; logic oe;
      check("R1 oe", {7'b0, bus_oe}, 8'h00);
      check("R1 flush", {7'b0, lnk_flush}, 8'h00);
      check("R1 overflow", {7'b0, tx_overflow}, 8'h00);
      bus_read(1'b1, d, oe);
      check("R1 status", d, 8'h02);
   endtask

   task automatic t_order_and_empty();
      logic [7:0] d; logic oe;
      rx_load(8'hA1); rx_load(8'hB2); rx_load(8'hC3);
      bus_read(1'b1, d, oe);
      check("R4 status rx data", d, 8'h03);
      bus_read(1'b0, d, oe);
      check("R3 first byte", d, 8'hA1);
      check("R10 oe during read", {7'b0, oe}, 8'h01);
      check("R10 oe after read", {7'b0, bus_oe}, 8'h00);
      bus_read(1'b0, d, oe);
      check("R3 second byte", d, 8'hB2);
      bus_read(1'b0, d, oe);
      check("R3 third byte", d, 8'hC3);
      bus_read(1'b0, d, oe);
      check("R8 empty read repeats last", d, 8'hC3);
      bus_read(1'b1, d, oe);
      check("R8 status empty", d, 8'h02);
   endtask

   task automatic t_select_idle();
      logic [7:0] d; logic oe;
      int f0;
      rx_load(8'h5E);
      f0 = flush_cnt;
      @(negedge clk);
      bus_sel_n = 1'b1; bus_addr = 1'b0; bus_rd_n = 1'b0;
      repeat (5) @(negedge clk);
      check("R10 oe with select high", {7'b0, bus_oe}, 8'h00);
      bus_rd_n = 1'b1; bus_wr_n = 1'b0; bus_din = 8'h77;
      repeat (5) @(negedge clk);
      bus_addr = 1'b1;
      bus_wr_n = 1'b1; repeat (2) @(negedge clk);
      bus_wr_n = 1'b0; repeat (5) @(negedge clk);
      bus_wr_n = 1'b1; repeat (4) @(negedge clk);
      check("R2 no flush", 8'(flush_cnt - f0), 8'h00);
      check("R2 no tx push", {7'b0, lnk_tx_avail}, 8'h00);
      bus_read(1'b0, d, oe);
      check("R2 rx not popped", d, 8'h5E);
   endtask

   task automatic t_held_strobe();
      logic [7:0] d; logic oe;
      rx_load(8'h11); rx_load(8'h22);
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = 1'b0; bus_rd_n = 1'b0;
      repeat (20) @(negedge clk);
      check("R7 held read byte", bus_dout, 8'h11);
      bus_rd_n = 1'b1; bus_sel_n = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(1'b0, d, oe);
      check("R7 one pop only", d, 8'h22);
   endtask

   task automatic t_flush();
      logic oe; int f0;
      f0 = flush_cnt;
      bus_write(1'b1, 8'hEE, oe);
      check("R6 pulse on empty queue", 8'(flush_cnt - f0), 8'h01);
      check("R6 no byte stored", {7'b0, lnk_tx_avail}, 8'h00);
      check("R10 oe during write", {7'b0, oe}, 8'h00);
   endtask

   task automatic t_tx_fill();
      logic [7:0] d; logic oe;
      for (int i = 0; i < 4; i++) bus_write(1'b0, 8'h40 + 8'(i), oe);
      check("R9 no overflow yet", {7'b0, tx_overflow}, 8'h00);
      bus_read(1'b1, d, oe);
      check("R4 status tx full", d, 8'h00);
      bus_write(1'b0, 8'h99, oe);
      check("R9 overflow set", {7'b0, tx_overflow}, 8'h01);
      for (int i = 0; i < 4; i++) begin
         tx_take(d);
         check("R5 tx order", d, 8'h40 + 8'(i));
      end
      check("R9 dropped byte absent", {7'b0, lnk_tx_avail}, 8'h00);
      check("R9 overflow sticky", {7'b0, tx_overflow}, 8'h01);
   endtask

   task automatic t_link_flags();
      logic [7:0] d; logic oe;
      @(negedge clk);
      lnk_suspend = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(1'b1, d, oe);
      check("R11 suspend bit", d, 8'h06);
      lnk_suspend = 1'b0; lnk_configured = 1'b1;
      repeat (4) @(negedge clk);
      bus_read(1'b1, d, oe);
      check("R11 configured bit", d, 8'h0A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_order_and_empty();
      t_select_idle();
      t_held_strobe();
      t_flush();
      t_tx_fill();
      t_link_flags();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule